// File: doc/BRIEF.md
# Bloom Filter Forwarding Decision Unit

This unit makes the forwarding decision for a node in a network that routes by source. Each packet header carries a Bloom filter. The filter is the OR of the identifier tags of every link in the packet's delivery tree. For each of its outgoing interfaces, the node keeps only the tag for the outgoing direction. It stores several alternative tags per interface, and a small set-index field in the header selects which alternative is in force for that packet. An interface is selected when all bits of its selected tag are present in the filter. All interfaces are tested at once, so one header can select several ports. No hashing and no address table are involved.

The unit also holds a few virtual-tree tags. Each virtual-tree tag has its own port mask, so a match on it adds a whole group of ports with one test. The port the packet arrived on is always removed from the result. An empty result raises a drop flag.

Header fields enter on a valid/ready stream. The port bitmap leaves one cycle after acceptance on a second valid/ready stream. Tags are written through an address/data/write-enable port.

Top module: `bff_fwd_engine`

## Requirements
- R1: After reset, `out_valid` is low, `in_ready` is high and every stored tag and virtual mask is zero.
- R2: Port p is selected when every set bit of its tag for the chosen set is also set in `in_filter`. Extra filter bits do not prevent a match. A single missing bit prevents it.
- R3: A tag that is all zero never matches, whatever the filter holds.
- R4: `in_set` picks which of the NSETS tags of each port is tested. Tags of other sets have no effect on that packet.
- R5: Every matching port is set in `out_ports` at the same time (multicast). Bit p of `out_ports` stands for port p.
- R6: When a virtual tag (nonzero, all of its bits in the filter) matches, its configured port mask is ORed into the result.
- R7: If `in_port` < NPORTS, bit `in_port` of `out_ports` is forced to zero. A value of NPORTS or more (packet from the local host) removes nothing.
- R8: `out_drop` is high exactly when a valid result has an all-zero `out_ports`.
- R9: A header accepted in cycle n (`in_valid` and `in_ready`) appears with `out_valid` high in cycle n+1. `in_ready` equals `!out_valid || out_ready`. A result is held unchanged while `out_ready` is low.
- R10: A write does not affect a header accepted in the same cycle. It does affect every header accepted later.
- R11: Write address map with `cfg_we` high:
  - address p*NSETS+s writes the tag of port p, set s (all FW bits of `cfg_wdata`);
  - address NPORTS*NSETS+v writes virtual tag v;
  - address NPORTS*NSETS+NVIRT+v writes the mask of virtual tag v from `cfg_wdata[NPORTS-1:0]`;
  - any higher address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Tag write enable |
| cfg_addr | input | AW | Tag write address |
| cfg_wdata | input | FW | Tag or mask write data |
| in_valid | input | 1 | Header valid |
| in_ready | output | 1 | Header accepted when high together with in_valid |
| in_filter | input | FW | Header Bloom filter |
| in_set | input | SW | Tag set index |
| in_port | input | PW | Arrival port, NPORTS or above for local |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream takes result |
| out_ports | output | NPORTS | Selected output ports |
| out_drop | output | 1 | No port selected |

## Verification
Four properties are checked on every cycle by the assertions:
- the one-cycle result latency and the absence of spurious results (R9);
- the holding of a result under backpressure (R9);
- the agreement between the drop flag and an empty bitmap (R8);
- the removal of the arrival port (R7).

The bench's scenarios are the only way to show that the match rule, the all-zero tag rule, the set selection, virtual-tree expansion, the address map and the write-versus-accept ordering give the right bitmap. A behavioural model in the bench predicts each bitmap and compares it with the output on every clock.

// File: rtl/bff_pkg.sv
package bff_pkg;

    localparam int DEF_NPORTS = 4;
    localparam int DEF_FW     = 256;
    localparam int DEF_NSETS  = 4;
    localparam int DEF_NVIRT  = 2;

    typedef enum logic [1:0] {
        RGN_PTAG  = 2'd0,
        RGN_VTAG  = 2'd1,
        RGN_VMASK = 2'd2,
        RGN_NONE  = 2'd3
    } region_e;

    function automatic region_e region_of(input int addr, input int npt, input int nvirt);
        if (addr < npt)
            return RGN_PTAG;
        else if (addr < npt + nvirt)
            return RGN_VTAG;
        else if (addr < npt + 2 * nvirt)
            return RGN_VMASK;
        else
            return RGN_NONE;
    endfunction

endpackage

// File: rtl/bff_tag_store.sv
module bff_tag_store
    import bff_pkg::*;
#(
    parameter int NPORTS = DEF_NPORTS,
    parameter int FW     = DEF_FW,
    parameter int NSETS  = DEF_NSETS,
    parameter int NVIRT  = DEF_NVIRT,
    parameter int AW     = 5
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_we,
    input  logic [AW-1:0]                    cfg_addr,
    input  logic [FW-1:0]                    cfg_wdata,
    output logic [NPORTS*NSETS-1:0][FW-1:0]  ptag,
    output logic [NVIRT-1:0][FW-1:0]         vtag,
    output logic [NVIRT-1:0][NPORTS-1:0]     vmask
);
    localparam int NPT = NPORTS * NSETS;

    typedef struct packed {
        logic [NPT-1:0][FW-1:0]        ptag;
        logic [NVIRT-1:0][FW-1:0]      vtag;
        logic [NVIRT-1:0][NPORTS-1:0]  vmask;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        region_e rgn;
        int      a;
        s_d = s_q;
        a   = int'(cfg_addr);
        rgn = region_of(a, NPT, NVIRT);
        if (cfg_we) begin
            case (rgn)
                RGN_PTAG: begin
                    for (int i = 0; i < NPT; i++)
                        if (a == i) s_d.ptag[i] = cfg_wdata;
                end
                RGN_VTAG: begin
                    for (int i = 0; i < NVIRT; i++)
                        if (a == NPT + i) s_d.vtag[i] = cfg_wdata;
                end
                RGN_VMASK: begin
                    for (int i = 0; i < NVIRT; i++)
                        if (a == NPT + NVIRT + i) s_d.vmask[i] = cfg_wdata[NPORTS-1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign ptag  = s_q.ptag;
    assign vtag  = s_q.vtag;
    assign vmask = s_q.vmask;

endmodule

// File: rtl/bff_match.sv
module bff_match
    import bff_pkg::*;
#(
    parameter int NPORTS = DEF_NPORTS,
    parameter int FW     = DEF_FW,
    parameter int NSETS  = DEF_NSETS,
    parameter int NVIRT  = DEF_NVIRT,
    parameter int SW     = 2,
    parameter int PW     = 3
) (
    input  logic [FW-1:0]                    filter,
    input  logic [SW-1:0]                    set_idx,
    input  logic [PW-1:0]                    arr_port,
    input  logic [NPORTS*NSETS-1:0][FW-1:0]  ptag,
    input  logic [NVIRT-1:0][FW-1:0]         vtag,
    input  logic [NVIRT-1:0][NPORTS-1:0]     vmask,
    output logic [NPORTS-1:0]                hit
);
    logic [NPORTS-1:0] phit;
    logic [NVIRT-1:0]  vhit;
    logic [NPORTS-1:0] arr_oh;

    for (genvar gp = 0; gp < NPORTS; gp++) begin : g_port
        logic [FW-1:0] sel;
        always_comb begin
            sel = '0;
            for (int s = 0; s < NSETS; s++)
                if (set_idx == SW'(s)) sel = ptag[gp*NSETS + s];
        end
        assign phit[gp] = (|sel) && ((sel & ~filter) == '0);
    end

    for (genvar gv = 0; gv < NVIRT; gv++) begin : g_virt
        assign vhit[gv] = (|vtag[gv]) && ((vtag[gv] & ~filter) == '0);
    end

    always_comb begin
        arr_oh = '0;
        for (int p = 0; p < NPORTS; p++)
            if (int'(arr_port) == p) arr_oh[p] = 1'b1;
    end

    always_comb begin
        logic [NPORTS-1:0] acc;
        acc = phit;
        for (int v = 0; v < NVIRT; v++)
            if (vhit[v]) acc = acc | vmask[v];
        hit = acc & ~arr_oh;
    end

endmodule

// File: rtl/bff_fwd_engine.sv
module bff_fwd_engine
    import bff_pkg::*;
#(
    parameter int NPORTS = DEF_NPORTS,
    parameter int FW     = DEF_FW,
    parameter int NSETS  = DEF_NSETS,
    parameter int NVIRT  = DEF_NVIRT,
    localparam int SW    = (NSETS > 1) ? $clog2(NSETS) : 1,
    localparam int PW    = $clog2(NPORTS) + 1,
    localparam int NENT  = NPORTS * NSETS + 2 * NVIRT,
    localparam int AW    = $clog2(NENT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [FW-1:0]     cfg_wdata,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [FW-1:0]     in_filter,
    input  logic [SW-1:0]     in_set,
    input  logic [PW-1:0]     in_port,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [NPORTS-1:0] out_ports,
    output logic              out_drop
);
    logic [NPORTS*NSETS-1:0][FW-1:0] ptag;
    logic [NVIRT-1:0][FW-1:0]        vtag;
    logic [NVIRT-1:0][NPORTS-1:0]    vmask;
    logic [NPORTS-1:0]               hit;

    typedef struct packed {
        logic              valid;
        logic [NPORTS-1:0] ports;
        logic              drop;
    } res_t;

    res_t r_d, r_q;

    bff_tag_store #(
        .NPORTS(NPORTS), .FW(FW), .NSETS(NSETS), .NVIRT(NVIRT), .AW(AW)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .ptag     (ptag),
        .vtag     (vtag),
        .vmask    (vmask)
    );

    bff_match #(
        .NPORTS(NPORTS), .FW(FW), .NSETS(NSETS), .NVIRT(NVIRT), .SW(SW), .PW(PW)
    ) u_match (
        .filter  (in_filter),
        .set_idx (in_set),
        .arr_port(in_port),
        .ptag    (ptag),
        .vtag    (vtag),
        .vmask   (vmask),
        .hit     (hit)
    );

    assign in_ready = !r_q.valid || out_ready;

    always_comb begin
        r_d = r_q;
        if (in_valid && in_ready) begin
            r_d.valid = 1'b1;
            r_d.ports = hit;
            r_d.drop  = (hit == '0);
        end else if (out_ready) begin
            r_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

    assign out_valid = r_q.valid;
    assign out_ports = r_q.ports;
    assign out_drop  = r_q.drop;

endmodule

// File: rtl/bff_fwd_engine_chk.sv
module bff_fwd_engine_chk #(
    parameter int NPORTS = 4,
    parameter int PW     = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [PW-1:0]     in_port,
    input logic              out_valid,
    input logic              out_ready,
    input logic [NPORTS-1:0] out_ports,
    input logic              out_drop
);
    logic [NPORTS-1:0] arr_oh;
    always_comb begin
        arr_oh = '0;
        for (int p = 0; p < NPORTS; p++)
            if (int'(in_port) == p) arr_oh[p] = 1'b1;
    end

    a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && !(in_valid && in_ready)) |=> !out_valid);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_ports) && $stable(out_drop)));

    a_r8_drop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_drop == (out_ports == '0)));

    a_r7_no_return: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> ((out_ports & $past(arr_oh)) == '0));

endmodule

bind bff_fwd_engine bff_fwd_engine_chk #(
    .NPORTS(NPORTS), .PW(PW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_port  (in_port),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_ports(out_ports),
    .out_drop (out_drop)
);

// File: tb/sim_bff_fwd_engine.sv
module sim_bff_fwd_engine;
    localparam int NPORTS = 4;
    localparam int FW     = 256;
    localparam int NSETS  = 4;
    localparam int NVIRT  = 2;
    localparam int SW     = 2;
    localparam int PW     = 3;
    localparam int NPT    = NPORTS * NSETS;
    localparam int AW     = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [AW-1:0]     cfg_addr = '0;
    logic [FW-1:0]     cfg_wdata = '0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [FW-1:0]     in_filter = '0;
    logic [SW-1:0]     in_set = '0;
    logic [PW-1:0]     in_port = PW'(NPORTS);
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [NPORTS-1:0] out_ports;
    logic              out_drop;

    always #5 clk = ~clk;

    bff_fwd_engine #(.NPORTS(NPORTS), .FW(FW), .NSETS(NSETS), .NVIRT(NVIRT)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
        .in_filter(in_filter), .in_set(in_set), .in_port(in_port),
        .out_valid(out_valid), .out_ready(out_ready), .out_ports(out_ports),
        .out_drop(out_drop)
    );

    int    checks = 0;
    int    errors = 0;
    int    cyc    = 0;
    string cur    = "R1";

    logic [FW-1:0]     mt  [NPT];
    logic [FW-1:0]     mvt [NVIRT];
    logic [NPORTS-1:0] mvm [NVIRT];
    logic              m_valid = 1'b0;
    logic [NPORTS-1:0] m_ports = '0;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog expired act=%0d exp=<20000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h", cur, what, act, exp);
        end
    endtask

    function automatic logic [FW-1:0] bits3(input int a, input int b, input int c);
        logic [FW-1:0] t;
        t = '0;
        t[a] = 1'b1;
        t[b] = 1'b1;
        t[c] = 1'b1;
        return t;
    endfunction

    function automatic logic [NPORTS-1:0] model(input logic [FW-1:0] f, input int s, input int ap);
        logic [NPORTS-1:0] r;
        r = '0;
        for (int p = 0; p < NPORTS; p++)
            if (mt[p*NSETS + s] != '0 && (mt[p*NSETS + s] & ~f) == '0) r[p] = 1'b1;
        for (int v = 0; v < NVIRT; v++)
            if (mvt[v] != '0 && (mvt[v] & ~f) == '0) r = r | mvm[v];
        if (ap < NPORTS) r[ap] = 1'b0;
        return r;
    endfunction

    // one clock: inputs are already set after a falling edge
    task automatic tick();
        logic              er;
        logic              acc;
        logic [NPORTS-1:0] r;
        int                a;
        #1;
        er = !m_valid || out_ready;
        check(in_ready == er, "in_ready", 64'(in_ready), 64'(er));
        acc = in_valid && er;
        r = '0;
        if (acc) r = model(in_filter, int'(in_set), int'(in_port));
        if (cfg_we) begin
            a = int'(cfg_addr);
            if (a < NPT) mt[a] = cfg_wdata;
            else if (a < NPT + NVIRT) mvt[a - NPT] = cfg_wdata;
            else if (a < NPT + 2*NVIRT) mvm[a - NPT - NVIRT] = cfg_wdata[NPORTS-1:0];
        end
        if (acc) begin
            m_valid = 1'b1;
            m_ports = r;
        end else if (out_ready) begin
            m_valid = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        check(out_valid == m_valid, "out_valid", 64'(out_valid), 64'(m_valid));
        if (m_valid) begin
            check(out_ports == m_ports, "out_ports", 64'(out_ports), 64'(m_ports));
            check(out_drop == (m_ports == '0), "out_drop", 64'(out_drop), 64'(m_ports == '0));
        end
    endtask

    task automatic wr(input int a, input logic [FW-1:0] d);
        cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = d; in_valid = 1'b0;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic pkt(input logic [FW-1:0] f, input int s, input int ap);
        in_valid = 1'b1; in_filter = f; in_set = SW'(s); in_port = PW'(ap);
        tick();
        in_valid = 1'b0;
    endtask

    logic [FW-1:0] ta, tb_, tc, td, te, tv;

    initial begin
        for (int i = 0; i < NPT; i++) mt[i] = '0;
        for (int i = 0; i < NVIRT; i++) begin mvt[i] = '0; mvm[i] = '0; end
        ta = bits3(3, 17, 200);
        tb_ = bits3(5, 64, 130);
        tc = bits3(9, 99, 250);
        td = bits3(1, 77, 160);
        te = bits3(12, 45, 222);
        tv = bits3(30, 31, 190);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        cur = "R1";
        #1;
        check(out_valid == 1'b0, "out_valid after reset", 64'(out_valid), 64'd0);
        check(in_ready == 1'b1, "in_ready after reset", 64'(in_ready), 64'd1);
        @(negedge clk);
        // R3: cleared tags do not match an all-ones filter
        cur = "R3";
        pkt('1, 0, NPORTS);
        pkt('1, 3, NPORTS);

        // R11: address map
        cur = "R11";
        wr(0*NSETS + 0, ta);
        wr(1*NSETS + 0, tb_);
        wr(2*NSETS + 0, tc);
        wr(0*NSETS + 1, td);

        // R2 / R5
        cur = "R5";
        pkt(ta | tb_, 0, NPORTS);
        pkt(ta | tb_ | tc, 0, NPORTS);
        cur = "R2";
        pkt(ta | bits3(0, 100, 101), 0, NPORTS);
        pkt(ta & ~bits3(17, 17, 17), 0, NPORTS);
        pkt('0, 0, NPORTS);

        // R4: set selection
        cur = "R4";
        pkt(td, 1, NPORTS);
        pkt(td, 0, NPORTS);
        pkt(ta, 1, NPORTS);

        // R7: arrival port masked
        cur = "R7";
        pkt(ta | tb_, 0, 0);
        pkt(ta | tb_, 0, 1);
        pkt(ta, 0, 0);
        pkt(ta | tb_, 0, 7);

        // R6: virtual tag
        cur = "R6";
        wr(NPT + 0, tv);
        wr(NPT + NVIRT + 0, {{(FW-NPORTS){1'b0}}, 4'b1010});
        pkt(tv, 2, NPORTS);
        pkt(tv | tc, 0, 1);
        pkt(tv & ~bits3(31, 31, 31), 0, NPORTS);

        // R9: backpressure
        cur = "R9";
        out_ready = 1'b0;
        in_valid = 1'b1; in_filter = ta | tc; in_set = '0; in_port = PW'(NPORTS);
        tick();
        in_filter = tb_;
        repeat (3) tick();
        out_ready = 1'b1;
        tick();
        in_valid = 1'b0;
        tick();
        in_valid = 1'b1; in_filter = ta;
        repeat (3) tick();
        in_valid = 1'b0;
        tick();

        // R10: write in the same cycle as an accept
        cur = "R10";
        cfg_we = 1'b1; cfg_addr = AW'(3*NSETS + 0); cfg_wdata = te;
        in_valid = 1'b1; in_filter = te; in_set = '0; in_port = PW'(NPORTS);
        tick();
        cfg_we = 1'b0;
        tick();
        in_valid = 1'b0;
        tick();

        // R11: out-of-range address changes nothing
        cur = "R11";
        wr(31, '1);
        wr(NPT + 2*NVIRT, '1);
        pkt(tb_, 0, NPORTS);
        pkt(ta, 2, NPORTS);
        pkt('1, 0, NPORTS);

        // R8: drop on empty result after masking
        cur = "R8";
        pkt(tc, 0, 2);
        pkt(tc, 0, 3);

        repeat (2) tick();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule